// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-interface master for an Ethernet PHY. Software loads a 5-bit PHY address and a 5-bit PHY register address into byte registers, and for writes it also loads a 16-bit value. It then sets a read or write command bit in the control register. The engine shifts one complete management frame out on MDC/MDIO and, for a read, collects the PHY's 16-bit reply into the data register. The command bit clears by itself when the frame ends, so software polls that bit as its busy indication.

The same control register also holds manual pin-control bits. With the manual bit set, software drives the clock, data-out and output-enable pins directly and reads the synchronized MDIO input back. MDC comes from the system clock through a divider set by a parameter. MDIO changes only after a falling MDC edge, and reply data is sampled on rising edges.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, the PHY-address, PHY-register and data registers read 0x00, and the control register reads 0x02 (the input synchronizer resets to 1). The pins rest at mdc=0, mdio_oe=0, mdio_o=1.
- R2: Register map. 0x6C holds the PHY address and 0x71 the PHY register address; each stores bits 4:0, and bits 7:5 read 0. 0x72 is the low data byte and 0x73 the high data byte. 0x70 is control. Every other offset reads 0x00.
- R3: Control bits: 0 manual clock, 1 synchronized MDIO input (read-only), 2 manual data-out, 3 manual output enable, 4 manual mode, 5 write command, 6 read command. Bit 7 always reads 0, and writing it has no effect.
- R4: A write command sends 64 bits. They are 32 ones, start 01, opcode 01, PHY address, register address and turnaround 10, all MSB first, followed by the 16 data bits MSB first. mdio_oe stays high for all 64 bits.
- R5: A read command sends the same preamble and start, then opcode 10, the PHY address and the register address. mdio_oe is low for bits 46 through 63. The 16 bits sampled on MDC rising edges during bits 48..63, MSB first, appear at 0x73:0x72 once the command bit has cleared.
- R6: A command bit stays set for exactly 128*CLK_DIV clock cycles after the control write that set it, and then clears by itself.
- R7: During a frame, MDC has a period of 2*CLK_DIV clock cycles. mdio_o never changes while MDC is high.
- R8: While a command bit is set, writes to any register are ignored.
- R9: If a control write sets both command bits, only the read command bit is stored and a read is performed.
- R10: With manual mode set, mdc, mdio_o and mdio_oe follow control bits 0, 2 and 3, and bit 1 follows mdio_i after SYNC_STAGES cycles. A control write that sets manual mode stores no command bit.
- R11: With no command running and manual mode clear, mdc=0, mdio_oe=0 and mdio_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte register offset |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench captures the whole 64-bit frame and the output-enable pattern on each rising MDC edge. A wrong opcode, a turnaround bit that is off by one, or a release of the output enable one bit early or late therefore shows up as a mismatched word. The bench counts how many cycles the command bit stays set, so a divider or bit counter that is off by one changes the count. It also times the MDC period. Separate scenarios cover four cases: register writes issued mid-frame, which a design without the lockout would apply; a control write with both command bits set, which a design could turn into a write or store as an illegal pair; manual-mode writes carrying command bits, which should never start a frame; and the unused control bit 7, which must read back 0.

// File: rtl/mdio_eng_pkg.sv
`timescale 1ns/1ps
package mdio_eng_pkg;
   // register offsets: software decodes these, so they are fixed
   localparam logic [7:0] OFS_PHY  = 8'h6C;
   localparam logic [7:0] OFS_CTRL = 8'h70;
   localparam logic [7:0] OFS_REG  = 8'h71;
   localparam logic [7:0] OFS_DLO  = 8'h72;
   localparam logic [7:0] OFS_DHI  = 8'h73;

   // control bit positions
   localparam int B_MDC = 0;
   localparam int B_MDI = 1;
   localparam int B_MDO = 2;
   localparam int B_OE  = 3;
   localparam int B_MAN = 4;
   localparam int B_WR  = 5;
   localparam int B_RD  = 6;

   localparam int ADR_W      = 5;
   localparam int WORD_W     = 16;
   localparam int FRAME_BITS = 64;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int TA_IDX     = 46;
   localparam int DATA_IDX   = 48;

   typedef struct packed {
      logic man;
      logic oe;
      logic mdo;
      logic mdc;
   } man_ctl_t;

   typedef enum logic {PH_IDLE = 1'b0, PH_SHIFT = 1'b1} phase_t;
endpackage

// File: rtl/mdio_in_sync.sv
`timescale 1ns/1ps
module mdio_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) pipe <= '1;
         else        pipe <= d;
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_t,
   output logic fall_t
);
   localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

   logic [CNT_W-1:0] cnt;
   logic             mdc_q;
   logic             term;

   assign term   = run && (cnt == CNT_LAST);
   assign rise_t = term && !mdc_q;
   assign fall_t = term &&  mdc_q;
   assign mdc    = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         mdc_q <= 1'b0;
      end else if (term) begin
         cnt   <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
   import mdio_eng_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_rd,
   input  logic [ADR_W-1:0]  phy,
   input  logic [ADR_W-1:0]  regad,
   input  logic [WORD_W-1:0] wdata,
   input  logic              rise_t,
   input  logic              fall_t,
   input  logic              mdi_s,
   output logic              active,
   output logic              mdo,
   output logic              oe,
   output logic              done,
   output logic [WORD_W-1:0] rdata
);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_IDX);
   localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_IDX);

   phase_t                phase;
   logic                  rd_q;
   logic [IDX_W-1:0]      idx;
   logic [FRAME_BITS-1:0] sr;
   logic [WORD_W-1:0]     rx;
   logic [FRAME_BITS-1:0] frame_w;

   assign frame_w = {32'hFFFF_FFFF, 2'b01,
                     is_rd ? 2'b10 : 2'b01,
                     phy, regad,
                     is_rd ? 2'b11 : 2'b10,
                     is_rd ? {WORD_W{1'b1}} : wdata};

   assign active = (phase == PH_SHIFT);
   assign done   = active && fall_t && (idx == IDX_LAST);
   assign mdo    = active ? sr[FRAME_BITS-1] : 1'b1;
   assign oe     = active && !(rd_q && (idx >= IDX_TA));
   assign rdata  = rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         rd_q  <= 1'b0;
         idx   <= '0;
         sr    <= '1;
         rx    <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_SHIFT;
               rd_q  <= is_rd;
               idx   <= '0;
               sr    <= frame_w;
            end
            PH_SHIFT: begin
               if (rise_t && rd_q && (idx >= IDX_DATA))
                  rx <= {rx[WORD_W-2:0], mdi_s};
               if (fall_t) begin
                  if (idx == IDX_LAST) begin
                     phase <= PH_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                     sr  <= {sr[FRAME_BITS-2:0], 1'b1};
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
module mdio_regfile
   import mdio_eng_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        addr,
   input  logic [7:0]        wdata,
   input  logic              done,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              mdi_s,
   output logic [7:0]        rdata,
   output logic [ADR_W-1:0]  phy_q,
   output logic [ADR_W-1:0]  reg_q,
   output logic [WORD_W-1:0] data_q,
   output man_ctl_t          man_q,
   output logic              rd_go,
   output logic              wr_go,
   output logic              start,
   output logic              start_rd
);
   logic busy, wr_ok, ctrl_hit, cmd_rd, cmd_wr;

   assign busy     = rd_go | wr_go;
   assign wr_ok    = wr_en && !busy;
   assign ctrl_hit = wr_ok && (addr == OFS_CTRL);
   // manual mode suppresses commands; read wins over write
   assign cmd_rd   = wdata[B_RD] && !wdata[B_MAN];
   assign cmd_wr   = wdata[B_WR] && !wdata[B_RD] && !wdata[B_MAN];
   assign start    = ctrl_hit && (cmd_rd || cmd_wr);
   assign start_rd = cmd_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phy_q  <= '0;
         reg_q  <= '0;
         data_q <= '0;
         man_q  <= '0;
         rd_go  <= 1'b0;
         wr_go  <= 1'b0;
      end else if (done) begin
         if (rd_go) data_q <= rx_word;
         rd_go <= 1'b0;
         wr_go <= 1'b0;
      end else if (wr_ok) begin
         case (addr)
            OFS_PHY:  phy_q       <= wdata[ADR_W-1:0];
            OFS_REG:  reg_q       <= wdata[ADR_W-1:0];
            OFS_DLO:  data_q[7:0] <= wdata;
            OFS_DHI:  data_q[15:8] <= wdata;
            OFS_CTRL: begin
               man_q.man <= wdata[B_MAN];
               man_q.oe  <= wdata[B_OE];
               man_q.mdo <= wdata[B_MDO];
               man_q.mdc <= wdata[B_MDC];
               rd_go     <= cmd_rd;
               wr_go     <= cmd_wr;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         OFS_PHY:  rdata = {{(8-ADR_W){1'b0}}, phy_q};
         OFS_REG:  rdata = {{(8-ADR_W){1'b0}}, reg_q};
         OFS_DLO:  rdata = data_q[7:0];
         OFS_DHI:  rdata = data_q[15:8];
         OFS_CTRL: rdata = {1'b0, rd_go, wr_go, man_q.man, man_q.oe,
                            man_q.mdo, mdi_s, man_q.mdc};
         default:  rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/mdio_cmd_engine.sv
`timescale 1ns/1ps
module mdio_cmd_engine
   import mdio_eng_pkg::*;
#(
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       mdc,
   output logic       mdio_o,
   output logic       mdio_oe,
   input  logic       mdio_i
);
   if (CLK_DIV < 2) begin : g_bad_div
      $error("CLK_DIV must be at least 2");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES >= CLK_DIV) begin : g_bad_sync
      $error("SYNC_STAGES must be in 1..CLK_DIV-1");
   end

   logic              mdi_s;
   logic [ADR_W-1:0]  phy_q, reg_q;
   logic [WORD_W-1:0] data_q, rx_word;
   man_ctl_t          man_q;
   logic              man_en;
   logic              rd_go, wr_go, busy, start, start_rd;
   logic              active, eng_mdo, eng_oe, done;
   logic              eng_mdc, rise_t, fall_t;

   mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(mdio_i), .q(mdi_s));

   mdio_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .done(done), .rx_word(rx_word), .mdi_s(mdi_s),
      .rdata(reg_rdata), .phy_q(phy_q), .reg_q(reg_q), .data_q(data_q),
      .man_q(man_q), .rd_go(rd_go), .wr_go(wr_go), .start(start),
      .start_rd(start_rd));

   mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(active), .mdc(eng_mdc),
      .rise_t(rise_t), .fall_t(fall_t));

   mdio_frame_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .is_rd(start_rd),
      .phy(phy_q), .regad(reg_q), .wdata(data_q), .rise_t(rise_t),
      .fall_t(fall_t), .mdi_s(mdi_s), .active(active), .mdo(eng_mdo),
      .oe(eng_oe), .done(done), .rdata(rx_word));

   assign busy    = rd_go | wr_go;
   assign man_en  = man_q.man;
   assign mdc     = man_en ? man_q.mdc : eng_mdc;
   assign mdio_o  = man_en ? man_q.mdo : eng_mdo;
   assign mdio_oe = man_en ? man_q.oe  : eng_oe;
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
`timescale 1ns/1ps
module mdio_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mdc,
   input logic       mdio_o,
   input logic       mdio_oe,
   input logic       rd_go,
   input logic       wr_go,
   input logic       man_en,
   input logic [4:0] phy_q
);
   logic busy;
   assign busy = rd_go | wr_go;

   AST_ONE_CMD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_go, wr_go}));                                   // R9

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !man_en) |-> (!mdc && !mdio_oe && mdio_o));        // R11

   AST_MDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !man_en && mdc) |-> $stable(mdio_o));               // R7

   AST_MDC_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (!man_en && $stable(man_en) && !$stable(mdc)) |-> (busy || $past(busy))); // R6

   AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(phy_q));                   // R8

   AST_END_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !mdc);                                       // R6
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
   .mdio_oe(mdio_oe), .rd_go(rd_go), .wr_go(wr_go), .man_en(man_en),
   .phy_q(phy_q));

// File: tb/mdio_cmd_engine_tb.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb;
   localparam int DIV = 4;
   localparam int SYN = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       mdc, mdio_o, mdio_oe;
   logic       mdio_i = 1'b1;

   int checks = 0;
   int bad = 0;
   bit finished = 0;

   logic [63:0] cap_d = '0;
   logic [63:0] cap_oe = '0;

   always #10 clk = ~clk;

   mdio_cmd_engine #(.CLK_DIV(DIV), .SYNC_STAGES(SYN)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   // PHY side: record the last 64 bits seen on rising MDC
   always @(posedge mdc) begin
      cap_d  <= {cap_d[62:0], mdio_o};
      cap_oe <= {cap_oe[62:0], mdio_oe};
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #2;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] c;
      int guard = 0;
      do begin
         @(negedge clk);
         reg_read(8'h70, c);
         guard++;
      end while (c[6:5] != 2'b00 && guard < 10000);
   endtask

   task automatic load(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
      reg_write(8'h6C, {3'b0, p});
      reg_write(8'h71, {3'b0, r});
      reg_write(8'h72, d[7:0]);
      reg_write(8'h73, d[15:8]);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      @(negedge clk);
      reg_read(8'h6C, v); chk("R1 phy", v, 8'h00);
      reg_read(8'h71, v); chk("R1 reg", v, 8'h00);
      reg_read(8'h72, v); chk("R1 dlo", v, 8'h00);
      reg_read(8'h73, v); chk("R1 dhi", v, 8'h00);
      reg_read(8'h70, v); chk("R1 ctrl", v, 8'h02);
      chk("R1 pins", {mdc, mdio_oe, mdio_o}, 3'b001);
   endtask

   task automatic t_regmap();
      logic [7:0] v;
      reg_write(8'h6C, 8'hFF); reg_read(8'h6C, v); chk("R2 phy 5 bits", v, 8'h1F);
      reg_write(8'h71, 8'hEA); reg_read(8'h71, v); chk("R2 reg 5 bits", v, 8'h0A);
      reg_write(8'h72, 8'h5A); reg_write(8'h73, 8'hA5);
      reg_read(8'h72, v); chk("R2 data low", v, 8'h5A);
      reg_read(8'h73, v); chk("R2 data high", v, 8'hA5);
      reg_write(8'h74, 8'h33); reg_read(8'h74, v); chk("R2 unmapped", v, 8'h00);
      reg_write(8'h70, 8'h80); reg_read(8'h70, v); chk("R3 bit7 ignored", v, 8'h02);
      reg_write(8'h70, 8'h00); reg_read(8'h70, v); chk("R3 mdi bit not writable", v, 8'h02);
      chk("R11 idle pins", {mdc, mdio_oe, mdio_o}, 3'b001);
   endtask

   task automatic t_write_frame();
      realtime t1, t2;
      load(5'h13, 5'h0A, 16'hBEEF);
      reg_write(8'h70, 8'h20);
      @(posedge mdc); t1 = $realtime;
      @(posedge mdc); t2 = $realtime;
      chk("R7 mdc period", 64'(int'(t2 - t1)), 64'(2 * DIV * 20));
      wait_idle();
      chk("R4 write frame", cap_d,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hBEEF});
      chk("R4 oe held", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_busy_len();
      logic [7:0] c;
      int n = 0;
      load(5'h01, 5'h02, 16'h1234);
      reg_write(8'h70, 8'h20);
      forever begin
         reg_read(8'h70, c);
         if (c[5] == 1'b0 || n > 100000) break;
         n++;
         @(negedge clk);
      end
      chk("R6 busy length", 64'(n), 64'(128 * DIV));
   endtask

   task automatic t_read_frame();
      logic [7:0] lo, hi, c;
      logic [15:0] resp = 16'hC3A5;
      load(5'h05, 5'h1C, 16'h0000);
      reg_write(8'h70, 8'h40);
      reg_read(8'h70, c); chk("R5 read bit set", c & 8'h60, 8'h40);
      repeat (47) @(negedge mdc);
      mdio_i = 1'b0;                    // turnaround zero from PHY
      @(negedge mdc);
      for (int i = 15; i >= 0; i--) begin
         mdio_i = resp[i];
         @(negedge mdc);
      end
      mdio_i = 1'b1;
      wait_idle();
      chk("R5 read header", cap_d[63:18],
          {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h05, 5'h1C});
      chk("R5 oe released", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
      reg_read(8'h72, lo); reg_read(8'h73, hi);
      chk("R5 read data", {hi, lo}, resp);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] v;
      load(5'h0B, 5'h03, 16'h00FF);
      reg_write(8'h70, 8'h20);
      reg_write(8'h6C, 8'h1F);
      reg_write(8'h72, 8'h77);
      reg_write(8'h70, 8'h10);
      reg_read(8'h70, v); chk("R8 ctrl kept busy", v, 8'h22);
      wait_idle();
      reg_read(8'h6C, v); chk("R8 phy unchanged", v, 8'h0B);
      reg_read(8'h72, v); chk("R8 data unchanged", v, 8'hFF);
      reg_read(8'h70, v); chk("R8 manual not stored", v, 8'h02);
      chk("R8 frame used old data", cap_d[15:0], 16'h00FF);
   endtask

   task automatic t_both_bits();
      logic [7:0] v, hi;
      load(5'h02, 5'h04, 16'h5555);
      reg_write(8'h70, 8'h60);
      reg_read(8'h70, v); chk("R9 only read stored", v & 8'h60, 8'h40);
      wait_idle();
      chk("R9 read oe pattern", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
      reg_read(8'h72, v); reg_read(8'h73, hi);
      chk("R9 data from pulled-up line", {hi, v}, 16'hFFFF);
   endtask

   task automatic t_manual();
      logic [7:0] v;
      reg_write(8'h70, 8'h1D);
      chk("R10 pins follow bits", {mdc, mdio_o, mdio_oe}, 3'b111);
      reg_write(8'h70, 8'h18);
      chk("R10 oe only", {mdc, mdio_o, mdio_oe}, 3'b001);
      mdio_i = 1'b0;
      repeat (SYN + 1) @(negedge clk);
      reg_read(8'h70, v); chk("R10 mdi follows input", v, 8'h18);
      mdio_i = 1'b1;
      reg_write(8'h70, 8'h70);
      repeat (3) @(negedge clk);
      reg_read(8'h70, v); chk("R10 no command in manual", v, 8'h12);
      chk("R10 no frame started", {mdc, mdio_oe}, 2'b00);
      reg_write(8'h70, 8'h00);
      chk("R11 back to idle", {mdc, mdio_oe, mdio_o}, 3'b001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_write_frame();
      t_busy_len();
      t_read_frame();
      t_busy_ignore();
      t_both_bits();
      t_manual();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule